// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the general registers of a processor core that switches between several operating modes. Registers 0 to 7 are a single physical set seen by every mode. Registers 8 to 14 are partly banked, so a mode switch preserves the outgoing mode's private copies and brings in the incoming mode's copies. The fast-interrupt mode owns a full private set of registers 8 to 14. The other privileged modes own only private stack and link registers (13 and 14) and share 8 to 12 with user mode. A mode code with no defined meaning selects a dummy bank whose banked registers read as zero. The program counter (address 15) is not held here.

The core raises `mode_req_i` together with a 5-bit code on `mode_new_i`. If the new code maps to the same bank, only the mode output changes. Otherwise the block walks registers 8 to 14, one per cycle, saving and restoring each one, and holds `busy_o` high for the whole walk. One read port and one write port address a register number. Each port may name an explicit mode, and then it reaches that mode's stored copy instead of the live register.

Top module: `rf_banked_regfile`

## Requirements
- R1: After reset the mode output is 19 (supervisor), `busy_o` is low and every register reads zero.
- R2: Mode codes map to banks as follows: 0 and 16 user, 1 and 17 fast-interrupt, 2 and 18 interrupt, 3 and 19 supervisor, 23 abort, 27 undefined, 31 system. Every other code maps to the dummy bank.
- R3: The fast-interrupt bank keeps private copies of registers 8 to 14, so values written there survive a round trip through any other bank.
- R4: The user, interrupt, supervisor, abort and undefined banks each keep private registers 13 and 14, and they share registers 8 to 12.
- R5: On entering the fast-interrupt bank from a non-dummy bank, live registers 8 to 12 go into the shared copy. On leaving it for a non-dummy bank, they come back from that shared copy.
- R6: A mode request whose bank equals the current bank updates the mode output on the next cycle and never raises `busy_o`. System mode (31) uses the user bank, including its registers 13 and 14.
- R7: While the dummy bank is current, registers 8 to 14 read zero and writes to them are discarded. Leaving the dummy bank saves nothing.
- R8: With `rd_sel_mode_i` or `wr_sel_mode_i` set, an access to registers 8 to 14 for a mode whose bank is not current reaches that bank's stored copy. Registers 0 to 7 are always the live ones.
- R9: A request whose bank differs from the current bank raises `busy_o` from the next clock edge for exactly 7 cycles.
- R10: While `busy_o` is high, writes and mode requests are ignored and `rd_data_o` reads zero.
- R11: Address 15 reads zero and writes to it are discarded. A write issued together with a bank-changing request lands in the outgoing bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_req_i | input | 1 | Mode change request |
| mode_new_i | input | 5 | Requested mode code |
| cur_mode_o | output | 5 | Current mode code |
| busy_o | output | 1 | Register swap in progress |
| wr_en_i | input | 1 | Write enable |
| wr_sel_mode_i | input | 1 | Write targets `wr_mode_i` instead of the current mode |
| wr_mode_i | input | 5 | Explicit mode for the write |
| wr_addr_i | input | 4 | Write register number |
| wr_data_i | input | 32 | Write data |
| rd_sel_mode_i | input | 1 | Read targets `rd_mode_i` instead of the current mode |
| rd_mode_i | input | 5 | Explicit mode for the read |
| rd_addr_i | input | 4 | Read register number |
| rd_data_o | output | 32 | Read data (combinational) |

## Verification
Each register is written with a distinct value before the bench moves through the transitions normal to normal, normal to fast-interrupt, fast-interrupt to normal, into and out of the dummy bank, and same-bank switches such as user to system. A full read sweep after each transition separates shared registers from private ones and shows whether a lost save or a wrong restore slot occurred. Explicit-mode reads and writes against banks that are not current show whether the stored copy or the live register was reached. A pass through all 32 mode codes, with a register 13 marker written in each, exposes any wrong entry in the decode. Writes and requests issued during a swap confirm that they are dropped.

// File: rtl/rf_bank_pkg.sv
package rf_bank_pkg;
  localparam int MODE_W     = 5;
  localparam int BANK_LO    = 8;   // first banked register
  localparam int SHARED_HI  = 12;  // last register shared by the normal banks
  localparam int REG_SP     = 13;
  localparam int NUM_SPB    = 7;   // stack/link slots, indexed by bank
  localparam logic [MODE_W-1:0] MODE_RESET = 5'd19;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5,
    BK_DUM = 3'd6
  } bank_e;

  function automatic bank_e mode_to_bank(logic [MODE_W-1:0] m);
    bank_e b;
    case (m)
      5'd0, 5'd16, 5'd31: b = BK_USR;
      5'd1, 5'd17:        b = BK_FIQ;
      5'd2, 5'd18:        b = BK_IRQ;
      5'd3, 5'd19:        b = BK_SVC;
      5'd23:              b = BK_ABT;
      5'd27:              b = BK_UND;
      default:            b = BK_DUM;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/rf_mode_decode.sv
module rf_mode_decode
  import rf_bank_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output bank_e             bank_o
);
  assign bank_o = mode_to_bank(mode_i);
endmodule

// File: rtl/rf_swap_seq.sv
module rf_swap_seq #(
  parameter int STEPS  = 7,
  localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic [STEP_W-1:0] step_o
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

  logic              busy_q;
  logic [STEP_W-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= '0;
    end else if (busy_q) begin
      if (step_q == LAST) busy_q <= 1'b0;
      else                step_q <= step_q + 1'b1;
    end else if (start_i) begin
      busy_q <= 1'b1;
      step_q <= '0;
    end
  end

  assign busy_o = busy_q;
  assign step_o = step_q;

  assert_step_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (step_q <= LAST));
  assert_done_at_last_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> ($past(step_q) == LAST));
endmodule

// File: rtl/rf_banked_regfile.sv
module rf_banked_regfile
  import rf_bank_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 15,
  parameter int ADDR_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_req_i,
  input  logic [4:0]        mode_new_i,
  output logic [4:0]        cur_mode_o,
  output logic              busy_o,
  input  logic              wr_en_i,
  input  logic              wr_sel_mode_i,
  input  logic [4:0]        wr_mode_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_sel_mode_i,
  input  logic [4:0]        rd_mode_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int N_SHR    = SHARED_HI - BANK_LO + 1;
  localparam int SWAP_LEN = NUM_REGS - BANK_LO;
  localparam int STEP_W   = (SWAP_LEN > 1) ? $clog2(SWAP_LEN) : 1;
  localparam int LO_W     = (N_SHR > 1) ? $clog2(N_SHR) : 1;
  localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(BANK_LO);
  localparam logic [ADDR_W-1:0] A_SHI = ADDR_W'(SHARED_HI);
  localparam logic [ADDR_W-1:0] A_SP  = ADDR_W'(REG_SP);
  localparam logic [ADDR_W-1:0] A_NUM = ADDR_W'(NUM_REGS);

  // mode decode: 0 = requested, 1 = read port, 2 = write port
  logic [MODE_W-1:0] dec_mode [3];
  bank_e             dec_bank [3];
  assign dec_mode[0] = mode_new_i;
  assign dec_mode[1] = rd_mode_i;
  assign dec_mode[2] = wr_mode_i;

  for (genvar g = 0; g < 3; g++) begin : g_dec
    rf_mode_decode u_dec (.mode_i(dec_mode[g]), .bank_o(dec_bank[g]));
  end

  logic              busy;
  logic [STEP_W-1:0] step;
  logic              start;

  logic [MODE_W-1:0] cur_mode_q;
  bank_e             cur_bank_q, old_bank_q;
  logic [DATA_W-1:0] live_q   [NUM_REGS];
  logic [DATA_W-1:0] shared_q [N_SHR];
  logic [DATA_W-1:0] fiq_lo_q [N_SHR];
  logic [DATA_W-1:0] b13_q    [NUM_SPB];
  logic [DATA_W-1:0] b14_q    [NUM_SPB];

  assign start = mode_req_i && !busy && (dec_bank[0] != cur_bank_q);

  rf_swap_seq #(.STEPS(SWAP_LEN)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .busy_o (busy),
    .step_o (step)
  );

  // swap step decode
  logic [ADDR_W-1:0] sw_reg;
  logic [LO_W-1:0]   sw_lo;
  logic              sw_is_lo, sw_is_sp;
  assign sw_reg   = A_LO + ADDR_W'(step);
  assign sw_lo    = LO_W'(step);
  assign sw_is_lo = (sw_reg <= A_SHI);
  assign sw_is_sp = (sw_reg == A_SP);

  // write decode
  bank_e             wr_bank;
  logic              wr_ok;
  logic [LO_W-1:0]   wr_lo;
  assign wr_bank = wr_sel_mode_i ? dec_bank[2] : cur_bank_q;
  assign wr_ok   = wr_en_i && !busy && (wr_addr_i < A_NUM);
  assign wr_lo   = LO_W'(wr_addr_i - A_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_mode_q <= MODE_RESET;
      cur_bank_q <= BK_SVC;
      old_bank_q <= BK_SVC;
      for (int i = 0; i < NUM_REGS; i++) live_q[i] <= '0;
      for (int i = 0; i < N_SHR; i++) begin
        shared_q[i] <= '0;
        fiq_lo_q[i] <= '0;
      end
      for (int i = 0; i < NUM_SPB; i++) begin
        b13_q[i] <= '0;
        b14_q[i] <= '0;
      end
    end else if (busy) begin
      if (sw_is_lo) begin
        // save outgoing
        if (old_bank_q == BK_FIQ)
          fiq_lo_q[sw_lo] <= live_q[sw_reg];
        else if (old_bank_q != BK_DUM && cur_bank_q == BK_FIQ)
          shared_q[sw_lo] <= live_q[sw_reg];
        // restore incoming
        if (cur_bank_q == BK_FIQ)      live_q[sw_reg] <= fiq_lo_q[sw_lo];
        else if (cur_bank_q == BK_DUM) live_q[sw_reg] <= '0;
        else if (old_bank_q == BK_FIQ) live_q[sw_reg] <= shared_q[sw_lo];
      end else begin
        if (old_bank_q != BK_DUM) begin
          if (sw_is_sp) b13_q[old_bank_q] <= live_q[sw_reg];
          else          b14_q[old_bank_q] <= live_q[sw_reg];
        end
        if (cur_bank_q == BK_DUM) live_q[sw_reg] <= '0;
        else if (sw_is_sp)        live_q[sw_reg] <= b13_q[cur_bank_q];
        else                      live_q[sw_reg] <= b14_q[cur_bank_q];
      end
    end else begin
      if (wr_ok) begin
        if (wr_addr_i < A_LO)             live_q[wr_addr_i] <= wr_data_i;
        else if (wr_bank == BK_DUM)       ;  // discarded
        else if (wr_bank == cur_bank_q)   live_q[wr_addr_i] <= wr_data_i;
        else if (wr_addr_i <= A_SHI) begin
          if (wr_bank == BK_FIQ)          fiq_lo_q[wr_lo] <= wr_data_i;
          else if (cur_bank_q == BK_FIQ)  shared_q[wr_lo] <= wr_data_i;
          else                            live_q[wr_addr_i] <= wr_data_i;
        end
        else if (wr_addr_i == A_SP)       b13_q[wr_bank] <= wr_data_i;
        else                              b14_q[wr_bank] <= wr_data_i;
      end
      if (mode_req_i) begin
        cur_mode_q <= mode_new_i;
        if (start) begin
          old_bank_q <= cur_bank_q;
          cur_bank_q <= dec_bank[0];
        end
      end
    end
  end

  // read port
  bank_e             rd_bank;
  logic [LO_W-1:0]   rd_lo;
  logic [DATA_W-1:0] rd_val;
  assign rd_bank = rd_sel_mode_i ? dec_bank[1] : cur_bank_q;
  assign rd_lo   = LO_W'(rd_addr_i - A_LO);

  always_comb begin
    rd_val = '0;
    if (!busy && rd_addr_i < A_NUM) begin
      if (rd_addr_i < A_LO)             rd_val = live_q[rd_addr_i];
      else if (rd_bank == BK_DUM)       rd_val = '0;
      else if (rd_bank == cur_bank_q)   rd_val = live_q[rd_addr_i];
      else if (rd_addr_i <= A_SHI) begin
        if (rd_bank == BK_FIQ)          rd_val = fiq_lo_q[rd_lo];
        else if (cur_bank_q == BK_FIQ)  rd_val = shared_q[rd_lo];
        else                            rd_val = live_q[rd_addr_i];
      end
      else if (rd_addr_i == A_SP)       rd_val = b13_q[rd_bank];
      else                              rd_val = b14_q[rd_bank];
    end
  end

  assign rd_data_o  = rd_val;
  assign busy_o     = busy;
  assign cur_mode_o = cur_mode_q;

  assert_busy_from_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(mode_req_i));
  assert_mode_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(cur_mode_o));
  assert_same_bank_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_req_i && !busy_o && dec_bank[0] == cur_bank_q) |=> !busy_o);
  assert_dummy_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cur_bank_q == BK_DUM && !rd_sel_mode_i &&
     rd_addr_i >= A_LO && rd_addr_i < A_NUM) |-> (rd_data_o == '0));
endmodule

// File: tb/rf_banked_regfile_tb_top.sv
`timescale 1ns/1ps
module rf_banked_regfile_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_req_i = 1'b0;
  logic [4:0]  mode_new_i = '0;
  logic [4:0]  cur_mode_o;
  logic        busy_o;
  logic        wr_en_i = 1'b0;
  logic        wr_sel_mode_i = 1'b0;
  logic [4:0]  wr_mode_i = '0;
  logic [3:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        rd_sel_mode_i = 1'b0;
  logic [4:0]  rd_mode_i = '0;
  logic [3:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;

  always #10 clk_i = ~clk_i;

  rf_banked_regfile dut_i (
    .clk_i, .rst_ni, .mode_req_i, .mode_new_i, .cur_mode_o, .busy_o,
    .wr_en_i, .wr_sel_mode_i, .wr_mode_i, .wr_addr_i, .wr_data_i,
    .rd_sel_mode_i, .rd_mode_i, .rd_addr_i, .rd_data_o
  );

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  string tag = "R1";

  // reference model; banks: 0 usr 1 fiq 2 irq 3 svc 4 abt 5 und 6 dummy
  logic [31:0] m_live [15];
  logic [31:0] m_shr  [5];
  logic [31:0] m_fiq  [5];
  logic [31:0] m_b13  [7];
  logic [31:0] m_b14  [7];
  int          m_bank, m_mode, m_cnt;

  function automatic int bank_of(int md);
    if (md == 0 || md == 16 || md == 31) return 0;
    if (md == 1 || md == 17) return 1;
    if (md == 2 || md == 18) return 2;
    if (md == 3 || md == 19) return 3;
    if (md == 23) return 4;
    if (md == 27) return 5;
    return 6;
  endfunction

  function automatic logic [31:0] exp_rd(bit sel, int md, int a);
    int b;
    b = sel ? bank_of(md) : m_bank;
    if (m_cnt > 0 || a > 14) return 32'h0;
    if (a < 8) return m_live[a];
    if (b == 6) return 32'h0;
    if (b == m_bank) return m_live[a];
    if (a <= 12) begin
      if (b == 1) return m_fiq[a-8];
      return (m_bank == 1) ? m_shr[a-8] : m_live[a];
    end
    return (a == 13) ? m_b13[b] : m_b14[b];
  endfunction

  task automatic model_swap(int o, int n);
    for (int r = 8; r <= 12; r++) begin
      if (o == 1) m_fiq[r-8] = m_live[r];
      else if (o != 6 && n == 1) m_shr[r-8] = m_live[r];
      if (n == 1) m_live[r] = m_fiq[r-8];
      else if (n == 6) m_live[r] = 0;
      else if (o == 1) m_live[r] = m_shr[r-8];
    end
    if (o != 6) begin m_b13[o] = m_live[13]; m_b14[o] = m_live[14]; end
    m_live[13] = (n == 6) ? 32'h0 : m_b13[n];
    m_live[14] = (n == 6) ? 32'h0 : m_b14[n];
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 15; i++) m_live[i] = 0;
      for (int i = 0; i < 5; i++) begin m_shr[i] = 0; m_fiq[i] = 0; end
      for (int i = 0; i < 7; i++) begin m_b13[i] = 0; m_b14[i] = 0; end
      m_bank = 3; m_mode = 19; m_cnt = 0;
    end else if (m_cnt > 0) begin
      m_cnt--;
    end else begin
      if (wr_en_i && wr_addr_i != 15) begin
        int b, a;
        a = int'(wr_addr_i);
        b = wr_sel_mode_i ? bank_of(int'(wr_mode_i)) : m_bank;
        if (a < 8) m_live[a] = wr_data_i;
        else if (b == 6) ;
        else if (b == m_bank) m_live[a] = wr_data_i;
        else if (a <= 12) begin
          if (b == 1) m_fiq[a-8] = wr_data_i;
          else if (m_bank == 1) m_shr[a-8] = wr_data_i;
          else m_live[a] = wr_data_i;
        end
        else if (a == 13) m_b13[b] = wr_data_i;
        else m_b14[b] = wr_data_i;
      end
      if (mode_req_i) begin
        int nb;
        nb = bank_of(int'(mode_new_i));
        m_mode = int'(mode_new_i);
        if (nb != m_bank) begin
          model_swap(m_bank, nb);
          m_bank = nb;
          m_cnt = 7;
        end
      end
    end
  end

  task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h (t=%0t)", tag, what, got, exp, $time);
    end
  endtask

  // compare outputs against the model on every cycle
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("busy", {31'h0, busy_o}, {31'h0, m_cnt > 0});
      chk("mode", {27'h0, cur_mode_o}, 32'(m_mode));
      chk("rd_data", rd_data_o, exp_rd(rd_sel_mode_i, int'(rd_mode_i), int'(rd_addr_i)));
    end
  end

  task automatic cyc();
    @(posedge clk_i); #1;
  endtask

  task automatic wr(bit sel, int md, int a, logic [31:0] d);
    wr_en_i = 1; wr_sel_mode_i = sel; wr_mode_i = 5'(md);
    wr_addr_i = 4'(a); wr_data_i = d;
    cyc();
    wr_en_i = 0; wr_sel_mode_i = 0;
  endtask

  task automatic go_mode(int md);
    mode_req_i = 1; mode_new_i = 5'(md);
    cyc();
    mode_req_i = 0;
    while (busy_o) cyc();
  endtask

  task automatic sweep(bit sel, int md);
    rd_sel_mode_i = sel; rd_mode_i = 5'(md);
    for (int a = 0; a < 16; a++) begin rd_addr_i = 4'(a); cyc(); end
    rd_sel_mode_i = 0;
  endtask

  task automatic fill(logic [7:0] tg, int lo, int hi);
    for (int a = lo; a <= hi; a++) wr(0, 0, a, {tg, 16'h0, 8'(a)});
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    // R1: reset state
    tag = "R1"; sweep(0, 0);
    fill(8'hA0, 0, 14);
    // R6: same bank switch (supervisor 19 -> 3) keeps busy low
    tag = "R6"; go_mode(3); sweep(0, 0);
    // R4/R9: supervisor -> interrupt, private 13/14, shared 8-12
    tag = "R9"; go_mode(18);
    tag = "R4"; sweep(0, 0); fill(8'hB0, 8, 14); sweep(0, 0);
    go_mode(19); sweep(0, 0); sweep(1, 18);
    // R3/R5: into fast-interrupt and back
    tag = "R5"; go_mode(17); sweep(0, 0); fill(8'hC0, 8, 14);
    tag = "R3"; sweep(1, 16); sweep(1, 19);
    tag = "R5"; go_mode(16); sweep(0, 0); sweep(1, 17);
    fill(8'hD0, 8, 14);
    // R6: system mode shares user bank
    tag = "R6"; go_mode(31); sweep(0, 0); go_mode(0); sweep(0, 0);
    // R7: dummy bank
    tag = "R7"; go_mode(5); sweep(0, 0); fill(8'hE0, 8, 14); sweep(0, 0);
    sweep(1, 17); wr(1, 9, 13, 32'hDEAD0001); sweep(1, 9);
    go_mode(17); sweep(0, 0); go_mode(4); go_mode(16); sweep(0, 0);
    // R8: explicit-mode access
    tag = "R8"; wr(1, 27, 13, 32'h27270013); wr(1, 27, 14, 32'h27270014);
    wr(1, 17, 9, 32'h17170009); wr(1, 17, 3, 32'h03030303);
    sweep(1, 27); sweep(1, 17);
    go_mode(27); sweep(0, 0); go_mode(17); sweep(0, 0);
    wr(1, 16, 10, 32'h1616000A); wr(1, 2, 14, 32'h0202000E);
    sweep(1, 16); sweep(1, 18); go_mode(18); sweep(0, 0);
    // R10: writes and requests during a swap are dropped
    tag = "R10";
    mode_req_i = 1; mode_new_i = 5'd23; cyc();
    mode_new_i = 5'd1; wr_en_i = 1; wr_addr_i = 4'd13; wr_data_i = 32'hBAD0BAD0;
    rd_addr_i = 4'd13;
    repeat (3) cyc();
    mode_req_i = 0; wr_en_i = 0;
    while (busy_o) cyc();
    sweep(0, 0);
    // R11: address 15 and write landing in outgoing bank
    tag = "R11"; wr(0, 0, 15, 32'hFFFF0015); sweep(0, 0);
    wr_en_i = 1; wr_addr_i = 4'd14; wr_data_i = 32'h0B0B0B0B;
    mode_req_i = 1; mode_new_i = 5'd19; cyc();
    wr_en_i = 0; mode_req_i = 0;
    while (busy_o) cyc();
    sweep(0, 0); sweep(1, 23);
    // R2: every mode code, marker in register 13
    tag = "R2";
    for (int c = 0; c < 32; c++) begin
      go_mode(c);
      wr(0, 0, 13, 32'h5A000000 | 32'(c));
      rd_sel_mode_i = 0; rd_addr_i = 4'd13; cyc();
    end
    for (int c = 0; c < 32; c++) begin
      rd_sel_mode_i = 1; rd_mode_i = 5'(c); rd_addr_i = 4'd13; cyc();
      rd_addr_i = 4'd8; cyc();
    end
    rd_sel_mode_i = 0;
    cyc();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule